// File: doc/BRIEF.md
# ADC Host Command Sequencer

This block is the host-side master for a 16-bit successive-approximation converter that talks over a four-wire serial link (chip select, serial clock, host-to-device data, device-to-host data) plus a strobe line from the device. A request port takes the input range (unipolar or bipolar), the conversion clock source (internal or external), an operation code (short acquisition, long acquisition, calibration, power-down) and three port bits for the device's general-purpose outputs. The sequencer turns these into an 8-bit control word and shifts it out. It generates the serial clock from the system clock through a programmable half-period divider.

The frame that follows depends on the request. An external-clock conversion runs a fixed number of serial clocks: 24 for short acquisition and 32 for long acquisition. In long acquisition the eight bits read right after the control word are discarded. For an internal-clock conversion the sequencer holds the serial clock low until the strobe rises, then reads 16 bits. A calibration ends on a strobe edge. That edge is rising in internal mode and falling in external mode, and in external mode the clock keeps running while the sequencer waits. A wait that lasts too long ends with an error flag. The result is presented sign-extended for bipolar conversions and zero-extended for unipolar ones.

Top module: `adc_cmd_seq`

## Requirements
- R1: After reset, cs_no is 1, sclk_o is 0, req_ready_o is 1, done_o, res_valid_o and err_o are 0, and result_o is 0.
- R2: The control word is sent MSB first on din_o. Bit 7 is 1, bit 6 is unipolar, bit 5 is internal clock, bits 4:3 are the operation code (00 short, 01 calibrate, 10 power-down, 11 long) and bits 2:0 are the port bits. din_o changes only while sclk_o is low, so it is stable across every rising edge.
- R3: Every sclk_o high phase lasts exactly SCLK_HALF system clocks. cs_no is low for at least CS_SETUP cycles before the first rising sclk_o edge of a frame.
- R4: An external-clock short-acquisition conversion runs exactly 24 sclk_o cycles. result_o holds the 16 dout_i bits sampled on rising edges 9 to 24, MSB first, and res_valid_o pulses with done_o.
- R5: An external-clock long-acquisition conversion runs exactly 32 sclk_o cycles. The bits sampled on rising edges 9 to 16 are discarded and the result is taken from rising edges 17 to 32.
- R6: An internal-clock conversion sends the 8-bit control word and then holds sclk_o low until a rising edge on sstrb_i. After that edge it reads 16 bits, so the frame has 24 rising edges in total.
- R7: A calibration request sends only the control word and then waits for a strobe edge: rising when the internal clock is selected, falling when the external clock is selected. In external mode sclk_o keeps toggling during the wait. The request completes with done_o and without res_valid_o, and result_o is unchanged.
- R8: A power-down request (code 10) runs exactly 8 sclk_o cycles, completes with done_o without res_valid_o, and leaves result_o unchanged.
- R9: A bipolar result is sign-extended from bit 15 to OUT_W bits. A unipolar result is zero-extended.
- R10: req_ready_o is low from the cycle after a request is accepted until the frame ends. A request presented while req_ready_o is low is ignored and starts no frame. req_ready_o returns to 1 the cycle after done_o.
- R11: If the awaited strobe edge does not arrive within WAIT_LIMIT cycles, the frame ends with err_o and done_o set, res_valid_o low and result_o unchanged. cs_no then goes high and the sequencer returns to idle.
- R12: cs_no is low for the whole frame and high in idle. sclk_o is never high while cs_no is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request strobe, taken when req_ready_o is high |
| req_unipolar_i | input | 1 | 1 selects unipolar range, 0 bipolar |
| req_intclk_i | input | 1 | 1 selects the device's internal conversion clock |
| req_mode_i | input | 2 | Operation code: 00 short, 01 calibrate, 10 power-down, 11 long |
| req_port_i | input | 3 | Port bits sent in the control word |
| req_ready_o | output | 1 | Sequencer idle and able to take a request |
| done_o | output | 1 | One-cycle pulse at the end of every frame |
| res_valid_o | output | 1 | With done_o: result_o holds a new conversion result |
| err_o | output | 1 | With done_o: strobe wait timed out |
| result_o | output | OUT_W | Last conversion result, sign- or zero-extended |
| cs_no | output | 1 | Active-low chip select to the converter |
| sclk_o | output | 1 | Serial clock to the converter |
| din_o | output | 1 | Serial data to the converter |
| dout_i | input | 1 | Serial data from the converter |
| sstrb_i | input | 1 | Strobe from the converter |

## Verification
The bench builds the sequencer with SCLK_HALF=2, CS_SETUP=3, WAIT_LIMIT=200 and OUT_W=24. A half period of two cycles makes each serial phase span several system clocks, so the divider count and the hold of din_o across a rising edge are both observed. A limit of 200 cycles lets the strobe timeout fire within a short run. An output width of 24 leaves eight extension bits whose sign or zero fill can be seen directly on the port.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [1:0] {
    ACQ_SHORT = 2'b00,
    ACQ_CAL   = 2'b01,
    ACQ_PDOWN = 2'b10,
    ACQ_LONG  = 2'b11
  } acq_mode_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_SETUP,
    S_CMD,
    S_WAIT,
    S_READ,
    S_DONE
  } seq_state_e;

  typedef struct packed {
    logic      unipolar;
    logic      intclk;
    acq_mode_e mode;
    logic [2:0] port;
  } cmd_cfg_t;

  localparam int CMD_BITS = 8;

  function automatic logic [7:0] ctl_byte(cmd_cfg_t c);
    return {1'b1, c.unipolar, c.intclk, c.mode, c.port};
  endfunction

endpackage

// File: rtl/adc_seq_sclk.sv
module adc_seq_sclk #(
  parameter int HALF = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic sclk_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt_q;
  logic          sclk_q;
  logic          tick;

  assign tick   = en_i && (cnt_q == CW'(HALF - 1));
  assign rise_o = tick & ~sclk_q;
  assign fall_o = tick & sclk_q;
  assign sclk_o = sclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else if (!en_i) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else if (tick) begin
      cnt_q  <= '0;
      sclk_q <= ~sclk_q;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  // R3: phase only changes on a divider tick
  p_phase_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !tick |=> $stable(sclk_o));

  p_park_low_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !sclk_o);

endmodule

// File: rtl/adc_seq_rx.sv
module adc_seq_rx #(
  parameter int RES_W = 16,
  parameter int OUT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             shift_i,
  input  logic             bit_i,
  input  logic             load_i,
  input  logic             signed_i,
  output logic [OUT_W-1:0] result_o
);
  logic [RES_W-1:0] sh_q;
  logic [OUT_W-1:0] res_q;
  logic [OUT_W-1:0] ext;

  generate
    if (OUT_W > RES_W) begin : g_ext
      assign ext = {{(OUT_W-RES_W){signed_i & sh_q[RES_W-1]}}, sh_q};

      // R9: fill bits match the range selected
      p_zero_fill_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_i && !signed_i |=> result_o[OUT_W-1:RES_W] == '0);

      p_sign_fill_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_i && signed_i |=> (&result_o[OUT_W-1:RES_W-1]) || !(|result_o[OUT_W-1:RES_W-1]));
    end else begin : g_trunc
      assign ext = sh_q[OUT_W-1:0];
    end
  endgenerate

  // shift keeps only the newest RES_W bits, older ones fall off the top
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      res_q <= '0;
    end else begin
      if (shift_i) sh_q  <= {sh_q[RES_W-2:0], bit_i};
      if (load_i)  res_q <= ext;
    end
  end

  assign result_o = res_q;

endmodule

// File: rtl/adc_cmd_seq.sv
module adc_cmd_seq
  import adc_seq_pkg::*;
#(
  parameter int SCLK_HALF  = 4,
  parameter int CS_SETUP   = 4,
  parameter int WAIT_LIMIT = 100000,
  parameter int RES_W      = 16,
  parameter int OUT_W      = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic             req_unipolar_i,
  input  logic             req_intclk_i,
  input  logic [1:0]       req_mode_i,
  input  logic [2:0]       req_port_i,
  output logic             req_ready_o,
  output logic             done_o,
  output logic             res_valid_o,
  output logic             err_o,
  output logic [OUT_W-1:0] result_o,
  output logic             cs_no,
  output logic             sclk_o,
  output logic             din_o,
  input  logic             dout_i,
  input  logic             sstrb_i
);
  localparam int SW       = (CS_SETUP > 1) ? $clog2(CS_SETUP) : 1;
  localparam int TW       = $clog2(WAIT_LIMIT + 1);
  localparam int SHORT_RD = RES_W;
  localparam int LONG_RD  = RES_W + CMD_BITS;
  localparam int BW       = $clog2(LONG_RD + 1);

  seq_state_e    state_q;
  cmd_cfg_t      cfg_q;
  logic [BW-1:0] bit_q;
  logic [SW-1:0] setup_q;
  logic [TW-1:0] wait_q;
  logic          ev_q, err_q, sstrb_q;

  logic          clk_en, rise, fall, ev, exit_ok, timeout, last_rd, is_conv;
  logic [7:0]    cbyte;
  logic [BW-1:0] rd_len;

  assign cbyte   = ctl_byte(cfg_q);
  assign is_conv = (cfg_q.mode == ACQ_SHORT) || (cfg_q.mode == ACQ_LONG);
  assign rd_len  = (cfg_q.mode == ACQ_LONG && !cfg_q.intclk) ? BW'(LONG_RD) : BW'(SHORT_RD);
  assign last_rd = (bit_q == rd_len - 1'b1);
  assign clk_en  = (state_q == S_CMD) || (state_q == S_READ) ||
                   (state_q == S_WAIT && !cfg_q.intclk);
  assign ev      = cfg_q.intclk ? (sstrb_i & ~sstrb_q) : (~sstrb_i & sstrb_q);
  // external-clock waits leave only on a falling tick so SCLK ends low
  assign exit_ok = cfg_q.intclk || fall;
  assign timeout = (wait_q >= TW'(WAIT_LIMIT - 1));

  adc_seq_sclk #(.HALF(SCLK_HALF)) u_sclk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (clk_en),
    .sclk_o (sclk_o),
    .rise_o (rise),
    .fall_o (fall)
  );

  adc_seq_rx #(.RES_W(RES_W), .OUT_W(OUT_W)) u_rx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .shift_i  ((state_q == S_READ) && rise),
    .bit_i    (dout_i),
    .load_i   ((state_q == S_READ) && fall && last_rd && is_conv),
    .signed_i (~cfg_q.unipolar),
    .result_o (result_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      cfg_q   <= '0;
      bit_q   <= '0;
      setup_q <= '0;
      wait_q  <= '0;
      ev_q    <= 1'b0;
      err_q   <= 1'b0;
      sstrb_q <= 1'b0;
    end else begin
      sstrb_q <= sstrb_i;
      case (state_q)
        S_IDLE: if (req_valid_i) begin
          cfg_q.unipolar <= req_unipolar_i;
          cfg_q.intclk   <= req_intclk_i;
          cfg_q.mode     <= acq_mode_e'(req_mode_i);
          cfg_q.port     <= req_port_i;
          setup_q        <= '0;
          err_q          <= 1'b0;
          state_q        <= S_SETUP;
        end
        S_SETUP: begin
          if (setup_q == SW'(CS_SETUP - 1)) begin
            bit_q   <= '0;
            state_q <= S_CMD;
          end else begin
            setup_q <= setup_q + 1'b1;
          end
        end
        S_CMD: if (fall) begin
          if (bit_q == BW'(CMD_BITS - 1)) begin
            bit_q  <= '0;
            wait_q <= '0;
            ev_q   <= 1'b0;
            if (cfg_q.mode == ACQ_PDOWN)                    state_q <= S_DONE;
            else if (cfg_q.mode == ACQ_CAL || cfg_q.intclk) state_q <= S_WAIT;
            else                                            state_q <= S_READ;
          end else begin
            bit_q <= bit_q + 1'b1;
          end
        end
        S_WAIT: begin
          if (!timeout) wait_q <= wait_q + 1'b1;
          if (ev)       ev_q   <= 1'b1;
          if ((ev_q || ev) && exit_ok) begin
            state_q <= (cfg_q.mode == ACQ_CAL) ? S_DONE : S_READ;
          end else if (timeout && exit_ok) begin
            err_q   <= 1'b1;
            state_q <= S_DONE;
          end
        end
        S_READ: if (fall) begin
          if (last_rd) state_q <= S_DONE;
          else         bit_q   <= bit_q + 1'b1;
        end
        S_DONE:  state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign din_o       = (state_q == S_CMD) && cbyte[3'd7 - bit_q[2:0]];
  assign req_ready_o = (state_q == S_IDLE);
  assign done_o      = (state_q == S_DONE);
  assign res_valid_o = done_o && !err_q && is_conv;
  assign err_o       = done_o && err_q;
  assign cs_no       = (state_q == S_IDLE) || (state_q == S_DONE);

  p_sclk_idle_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !sclk_o);

  p_din_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sclk_o) |-> $stable(din_o));

  p_accept_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o && req_valid_i |=> !req_ready_o && !cs_no);

  p_done_ret_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> req_ready_o);

  p_err_excl_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o && !res_valid_o);

  p_wait_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_WAIT) && cfg_q.intclk |-> !sclk_o);

endmodule

// File: tb/tb_adc_cmd_seq.sv
module tb_adc_cmd_seq;
  localparam int DIV = 2;
  localparam int CSU = 3;
  localparam int TO  = 200;
  localparam int OW  = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          req_valid = 1'b0, req_uni = 1'b0, req_int = 1'b0;
  logic [1:0]    req_mode = 2'b00;
  logic [2:0]    req_port = 3'b000;
  logic          ready, done, rvalid, err, cs_n, sclk, din;
  logic [OW-1:0] result;
  logic          dout = 1'b0;
  logic          sstrb = 1'b1;

  adc_cmd_seq #(
    .SCLK_HALF(DIV), .CS_SETUP(CSU), .WAIT_LIMIT(TO), .RES_W(16), .OUT_W(OW)
  ) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_unipolar_i(req_uni),
    .req_intclk_i(req_int), .req_mode_i(req_mode), .req_port_i(req_port),
    .req_ready_o(ready), .done_o(done), .res_valid_o(rvalid), .err_o(err),
    .result_o(result), .cs_no(cs_n), .sclk_o(sclk), .din_o(din),
    .dout_i(dout), .sstrb_i(sstrb)
  );

  int n_chk = 0, n_err = 0;
  int nrise = 0, nfall = 0, frames = 0, cs_cyc = 0, gap = 0, hi_cnt = 0, done_cnt = 0;
  int v_cs = 0, v_hi = 0, v_din = 0;
  logic [7:0]    rx_byte = 8'h00;
  logic          prev_s = 1'b0, prev_c = 1'b1, prev_d = 1'b0;
  logic          val_seen = 1'b0, err_seen = 1'b0;
  logic [OW-1:0] res_seen = '0;
  bit            q[$];

  // behavioural device and link monitor, evaluated every clock
  always @(negedge clk) begin
    if (rst_n) begin
      if (cs_n && sclk) v_cs++;
      if (prev_c && !cs_n) begin frames++; nrise = 0; nfall = 0; cs_cyc = 0; end
      if (!cs_n) cs_cyc++;
      if (!prev_s && sclk) begin
        if (nrise == 0) gap = cs_cyc - 1;
        if (nrise < 8) rx_byte = {rx_byte[6:0], din};
        if (din !== prev_d) v_din++;
        nrise++;
        hi_cnt = 1;
      end else if (sclk) hi_cnt++;
      if (prev_s && !sclk) begin
        if (hi_cnt != DIV) v_hi++;
        nfall++;
        if (nfall > 8 && q.size() > 0) void'(q.pop_front());
      end
      if (done) begin done_cnt++; val_seen = rvalid; err_seen = err; res_seen = result; end
    end
    prev_s = sclk; prev_c = cs_n; prev_d = din;
    dout = (q.size() > 0) ? q[0] : 1'b0;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [OW-1:0] ext(input logic [15:0] w, input bit uni);
    return uni ? {8'h00, w} : {{8{w[15]}}, w};
  endfunction

  task automatic load_q(input logic [15:0] w, input bit junk);
    q.delete();
    if (junk) for (int i = 0; i < 8; i++) q.push_back(i[0]);
    for (int i = 15; i >= 0; i--) q.push_back(w[i]);
  endtask

  task automatic issue(input bit uni, input bit intc, input logic [1:0] m, input logic [2:0] p);
    @(negedge clk);
    req_uni = uni; req_int = intc; req_mode = m; req_port = p; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic wait_done(input int start);
    int k = 0;
    while (done_cnt == start && k < 4000) begin @(negedge clk); k++; end
    chk(done_cnt != start, "R10 frame completion", done_cnt, start + 1);
    @(negedge clk);
  endtask

  task automatic wait_falls(input int n);
    while (nfall < n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL R10 watchdog expired actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int d0, f0;
    logic [OW-1:0] held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(cs_n == 1'b1, "R1 cs_no", cs_n, 1);
    chk(sclk == 1'b0, "R1 sclk_o", sclk, 0);
    chk(ready == 1'b1, "R1 req_ready_o", ready, 1);
    chk(!done && !rvalid && !err, "R1 flags", {done, rvalid, err}, 0);
    chk(result == '0, "R1 result_o", result, 0);

    // R4 external short, bipolar negative
    load_q(16'h8001, 0); d0 = done_cnt;
    issue(0, 0, 2'b00, 3'b101); wait_done(d0);
    chk(rx_byte == 8'h85, "R2 control word short", rx_byte, 8'h85);
    chk(gap >= CSU, "R3 cs setup", gap, CSU);
    chk(nrise == 24, "R4 clock count", nrise, 24);
    chk(val_seen, "R4 res_valid", val_seen, 1);
    chk(res_seen == ext(16'h8001, 0), "R9 bipolar sign extension", res_seen, ext(16'h8001, 0));

    // R9 unipolar zero extension
    load_q(16'h8001, 0); d0 = done_cnt;
    issue(1, 0, 2'b00, 3'b010); wait_done(d0);
    chk(rx_byte == 8'hC2, "R2 control word unipolar", rx_byte, 8'hC2);
    chk(res_seen == ext(16'h8001, 1), "R9 unipolar zero extension", res_seen, ext(16'h8001, 1));

    // R5 external long, junk bits discarded
    load_q(16'h1234, 1); d0 = done_cnt;
    issue(0, 0, 2'b11, 3'b011); wait_done(d0);
    chk(rx_byte == 8'h9B, "R2 control word long", rx_byte, 8'h9B);
    chk(nrise == 32, "R5 clock count", nrise, 32);
    chk(res_seen == ext(16'h1234, 0), "R5 long result", res_seen, ext(16'h1234, 0));

    // R6 internal conversion
    sstrb = 1'b1;
    load_q(16'hA5C3, 0); d0 = done_cnt;
    issue(1, 1, 2'b00, 3'b111);
    wait_falls(8); sstrb = 1'b0;
    repeat (15) @(negedge clk);
    chk(nrise == 8, "R6 sclk held during conversion", nrise, 8);
    sstrb = 1'b1;
    wait_done(d0);
    chk(rx_byte == 8'hE7, "R2 control word internal", rx_byte, 8'hE7);
    chk(nrise == 24, "R6 total clocks", nrise, 24);
    chk(val_seen && res_seen == ext(16'hA5C3, 1), "R6 internal result", res_seen, ext(16'hA5C3, 1));
    held = result;

    // R7 internal calibration ends on strobe rising
    q.delete(); d0 = done_cnt;
    issue(0, 1, 2'b01, 3'b000);
    wait_falls(8); sstrb = 1'b0;
    repeat (20) @(negedge clk);
    sstrb = 1'b1;
    wait_done(d0);
    chk(rx_byte == 8'hA8, "R2 control word cal", rx_byte, 8'hA8);
    chk(nrise == 8, "R7 internal cal clocks", nrise, 8);
    chk(!val_seen && !err_seen, "R7 internal cal no result", {val_seen, err_seen}, 0);
    chk(result == held, "R7 result kept", result, held);

    // R7 external calibration ends on strobe falling with clock running
    sstrb = 1'b0;
    repeat (4) @(negedge clk);
    d0 = done_cnt;
    issue(0, 0, 2'b01, 3'b110);
    wait_falls(8); sstrb = 1'b1;
    repeat (30) @(negedge clk);
    sstrb = 1'b0;
    wait_done(d0);
    chk(rx_byte == 8'h8E, "R2 control word ext cal", rx_byte, 8'h8E);
    chk(nrise > 8, "R7 sclk runs in external cal", nrise, 9);
    chk(!val_seen && !err_seen && result == held, "R7 external cal no result", {val_seen, err_seen}, 0);

    // R8 power-down
    d0 = done_cnt;
    issue(0, 0, 2'b10, 3'b001); wait_done(d0);
    chk(rx_byte == 8'h91, "R2 control word power-down", rx_byte, 8'h91);
    chk(nrise == 8, "R8 clock count", nrise, 8);
    chk(!val_seen && result == held, "R8 result kept", result, held);

    // R10 request while busy is ignored
    load_q(16'h3C5A, 0); d0 = done_cnt;
    issue(0, 0, 2'b00, 3'b001);
    f0 = frames;
    while (nrise < 3) @(negedge clk);
    chk(ready == 1'b0, "R10 ready low while busy", ready, 0);
    req_uni = 1'b1; req_mode = 2'b10; req_port = 3'b111; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    wait_done(d0);
    chk(rx_byte == 8'h81 && nrise == 24, "R10 frame undisturbed", rx_byte, 8'h81);
    chk(res_seen == ext(16'h3C5A, 0), "R10 result undisturbed", res_seen, ext(16'h3C5A, 0));
    repeat (10) @(negedge clk);
    chk(frames == f0 && cs_n == 1'b1 && ready == 1'b1, "R10 no extra frame", frames, f0);
    held = result;

    // R11 strobe timeout
    sstrb = 1'b1;
    d0 = done_cnt;
    issue(0, 1, 2'b00, 3'b100); wait_done(d0);
    chk(rx_byte == 8'hA4, "R2 control word timeout case", rx_byte, 8'hA4);
    chk(err_seen && !val_seen, "R11 timeout flags", {err_seen, val_seen}, 2'b10);
    chk(result == held, "R11 result kept", result, held);
    chk(cs_n == 1'b1 && ready == 1'b1, "R11 back to idle", {cs_n, ready}, 2'b11);

    chk(v_cs == 0, "R12 sclk high with cs high", v_cs, 0);
    chk(v_hi == 0, "R3 high phase length", v_hi, 0);
    chk(v_din == 0, "R2 din stable at rising edge", v_din, 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule